// File: doc/BRIEF.md
# Receive Sample Source Selector

This block sits on the receive sample path, ahead of any filtering, and decides which I/Q pair goes downstream at each sample instant. Three sources are possible: the converter samples (normal operation), the transmit samples fed straight back (a digital loopback for exercising the receive chain without analog hardware), or a counting pattern produced inside the block (a known, predictable stream used for bring-up and link testing).

The block also produces its own sample instants. A rate divider counts master-clock cycles and raises an internal strobe once every N cycles, where N is the programmed divide value. At each strobe the chosen pair is captured into the output register, and a one-cycle valid pulse marks the new pair. The counting pattern comes in two shapes. In the narrow shape, I carries the count and Q carries its bitwise inverse. In the wide shape, a double-width count is split across the two channels, with its low half on I and its high half on Q.

Two control inputs govern the block. The enable input lets the divider run. The receive reset input clears the divider and the pattern count, and it overrides enable.

Top module: `rxsrc_select`

## Requirements
- R1: With mode bits 0 and 1 both clear, each output pair equals the converter I/Q captured at the strobe. Mode bit 2 on its own has no effect.
- R2: With mode bit 0 set and mode bit 1 clear, the outputs carry the transmit I/Q captured at the strobe (digital loopback).
- R3: With mode bit 1 set and bit 2 clear, out_i is the low SAMPLE_W bits of the pattern count and out_q is their bitwise inverse. The count is 0 after any reset and rises by one at every strobe, whatever the mode.
- R4: With mode bits 1 and 2 both set, out_i is the low SAMPLE_W bits of a 2*SAMPLE_W-bit count and out_q is its high SAMPLE_W bits. A carry out of the low half shows up on out_q.
- R5: When mode bits 0 and 1 are both set, the counting pattern is output and the loopback samples are not.
- R6: While running, out_valid pulses for exactly one cycle every N cycles, where N is rate_div. The first pulse comes N cycles after enable rises.
- R7: A rate_div value of 0 or 1 behaves exactly like a value of 2.
- R8: out_valid stays low while rx_en is low. The pattern count holds its value while rx_en is low, and counting resumes from that value.
- R9: While rx_rst is high, no valid is produced even if rx_en is high. rx_rst returns the pattern count to 0 and restarts the divider phase.
- R10: After rst_n is asserted, out_valid, out_i and out_q are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; lets the rate divider run |
| rx_rst | input | 1 | Receive reset; clears the divider and the pattern count, overrides rx_en |
| mode_word | input | 3 | Bit 0 selects loopback, bit 1 selects counting, bit 2 selects the wide count |
| rate_div | input | DIV_W | Master-clock cycles per sample |
| adc_i | input | SAMPLE_W | Converter I sample |
| adc_q | input | SAMPLE_W | Converter Q sample |
| tx_i | input | SAMPLE_W | Transmit I sample |
| tx_q | input | SAMPLE_W | Transmit Q sample |
| out_i | output | SAMPLE_W | Selected I sample |
| out_q | output | SAMPLE_W | Selected Q sample |
| out_valid | output | 1 | One-cycle pulse marking a new output pair |

## Verification
The assertions assume that mode_word, rate_div and the sample inputs change only between strobes and not on the strobe cycle itself. They also assume that rate_div is stable whenever a pulse-spacing property is in force. The bench drives every input on the falling edge. It changes the mode and the divide value only while rx_en is low, and it holds each burst's sample values constant. Because of this, every captured pair and every valid spacing can be predicted from the burst settings alone. The scoreboard model tracks the pattern count across bursts, disables and receive resets, and the wide-count run is long enough to carry into the high half.

// File: rtl/rxsrc_pkg.sv
package rxsrc_pkg;

   localparam int MODE_W   = 3;
   localparam int LOOP_BIT = 0;
   localparam int CNT_BIT  = 1;
   localparam int WIDE_BIT = 2;

   typedef enum logic [1:0] {
      SRC_CONV       = 2'd0,
      SRC_LOOP       = 2'd1,
      SRC_CNT_NARROW = 2'd2,
      SRC_CNT_WIDE   = 2'd3
   } src_sel_e;

   // Counting outranks loopback; the wide flag only matters with counting.
   function automatic src_sel_e pick_src(input logic [MODE_W-1:0] mode, input bit wide_ok);
      src_sel_e r;
      if (mode[CNT_BIT]) begin
         r = (wide_ok && mode[WIDE_BIT]) ? SRC_CNT_WIDE : SRC_CNT_NARROW;
      end else if (mode[LOOP_BIT]) begin
         r = SRC_LOOP;
      end else begin
         r = SRC_CONV;
      end
      return r;
   endfunction

endpackage

// File: rtl/rxsrc_rate_div.sv
module rxsrc_rate_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

   logic [DIV_W-1:0] phase;
   logic [DIV_W-1:0] eff_div;
   logic [DIV_W-1:0] last_phase;

   initial assert (DIV_W >= 2) else $error("rxsrc_rate_div: DIV_W must be at least 2");

   always_comb begin
      eff_div    = (div < MIN_DIV) ? MIN_DIV : div;
      last_phase = eff_div - DIV_W'(1);
      tick       = run && !clr && (phase >= last_phase);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (clr || !run) begin
         phase <= '0;
      end else if (tick) begin
         phase <= '0;
      end else begin
         phase <= phase + DIV_W'(1);
      end
   end

   // The divide value is at least 2, so two strobes never land on adjacent cycles.
   p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // A stopped or cleared divider starts over from phase zero.
   p_phase_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr || !run) |=> (phase == '0));

endmodule

// File: rtl/rxsrc_pattern_cnt.sv
module rxsrc_pattern_cnt #(
   parameter int SAMPLE_W = 16,
   parameter bit WIDE_EN  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  step,
   output logic [2*SAMPLE_W-1:0] value
);
   localparam int CNT_W = WIDE_EN ? 2*SAMPLE_W : SAMPLE_W;

   logic [CNT_W-1:0] cnt;

   initial assert (SAMPLE_W >= 2) else $error("rxsrc_pattern_cnt: SAMPLE_W must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   generate
      if (WIDE_EN) begin : g_wide
         assign value = cnt;
      end else begin : g_narrow
         assign value = {{SAMPLE_W{1'b0}}, cnt};
      end
   endgenerate

   p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step) |=> $stable(cnt));

   p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && step) |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/rxsrc_out_stage.sv
module rxsrc_out_stage
   import rxsrc_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  tick,
   input  src_sel_e              sel,
   input  logic [SAMPLE_W-1:0]   adc_i,
   input  logic [SAMPLE_W-1:0]   adc_q,
   input  logic [SAMPLE_W-1:0]   tx_i,
   input  logic [SAMPLE_W-1:0]   tx_q,
   input  logic [2*SAMPLE_W-1:0] cnt,
   output logic [SAMPLE_W-1:0]   out_i,
   output logic [SAMPLE_W-1:0]   out_q,
   output logic                  out_valid
);
   logic [SAMPLE_W-1:0] nxt_i;
   logic [SAMPLE_W-1:0] nxt_q;
   logic [SAMPLE_W-1:0] cnt_lo;
   logic [SAMPLE_W-1:0] cnt_hi;

   assign cnt_lo = cnt[SAMPLE_W-1:0];
   assign cnt_hi = cnt[2*SAMPLE_W-1:SAMPLE_W];

   always_comb begin
      nxt_i = adc_i;
      nxt_q = adc_q;
      unique case (sel)
         SRC_CONV: begin
            nxt_i = adc_i;
            nxt_q = adc_q;
         end
         SRC_LOOP: begin
            nxt_i = tx_i;
            nxt_q = tx_q;
         end
         SRC_CNT_NARROW: begin
            nxt_i = cnt_lo;
            nxt_q = ~cnt_lo;
         end
         SRC_CNT_WIDE: begin
            nxt_i = cnt_lo;
            nxt_q = cnt_hi;
         end
         default: begin
            nxt_i = adc_i;
            nxt_q = adc_q;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_i     <= '0;
         out_q     <= '0;
         out_valid <= 1'b0;
      end else if (clr) begin
         out_i     <= '0;
         out_q     <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= tick;
         if (tick) begin
            out_i <= nxt_i;
            out_q <= nxt_q;
         end
      end
   end

   p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> ($stable(out_i) && $stable(out_q)));

   p_narrow_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr && sel == SRC_CNT_NARROW) |=> (out_q == ~out_i));

endmodule

// File: rtl/rxsrc_select.sv
module rxsrc_select
   import rxsrc_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int DIV_W    = 8,
   parameter bit WIDE_EN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_en,
   input  logic                rx_rst,
   input  logic [MODE_W-1:0]   mode_word,
   input  logic [DIV_W-1:0]    rate_div,
   input  logic [SAMPLE_W-1:0] adc_i,
   input  logic [SAMPLE_W-1:0] adc_q,
   input  logic [SAMPLE_W-1:0] tx_i,
   input  logic [SAMPLE_W-1:0] tx_q,
   output logic [SAMPLE_W-1:0] out_i,
   output logic [SAMPLE_W-1:0] out_q,
   output logic                out_valid
);
   logic                  run;
   logic                  tick;
   src_sel_e              sel;
   logic [2*SAMPLE_W-1:0] cnt_val;

   assign run = rx_en && !rx_rst;
   assign sel = pick_src(mode_word, WIDE_EN);

   rxsrc_rate_div #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .clr   (rx_rst),
      .div   (rate_div),
      .tick  (tick)
   );

   rxsrc_pattern_cnt #(.SAMPLE_W(SAMPLE_W), .WIDE_EN(WIDE_EN)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rx_rst),
      .step  (tick),
      .value (cnt_val)
   );

   rxsrc_out_stage #(.SAMPLE_W(SAMPLE_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (rx_rst),
      .tick      (tick),
      .sel       (sel),
      .adc_i     (adc_i),
      .adc_q     (adc_q),
      .tx_i      (tx_i),
      .tx_q      (tx_q),
      .cnt       (cnt_val),
      .out_i     (out_i),
      .out_q     (out_q),
      .out_valid (out_valid)
   );

   p_valid_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(rx_en));

   p_no_valid_in_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rst |=> !out_valid);

   p_loopback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !rx_rst && mode_word[CNT_BIT] == 1'b0 && mode_word[LOOP_BIT])
         |=> (out_i == $past(tx_i) && out_q == $past(tx_q)));

   p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !rx_rst && mode_word[CNT_BIT] == 1'b0 && mode_word[LOOP_BIT] == 1'b0)
         |=> (out_i == $past(adc_i) && out_q == $past(adc_q)));

endmodule

// File: tb/rxsrc_select_tb.sv
module rxsrc_select_tb;
   localparam int SW = 8;
   localparam int DW = 8;

   typedef struct {
      logic [SW-1:0] i;
      logic [SW-1:0] q;
      int            gap;
      string         tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_en = 1'b0;
   logic          rx_rst = 1'b0;
   logic [2:0]    mode_word = '0;
   logic [DW-1:0] rate_div = DW'(4);
   logic [SW-1:0] adc_i = '0, adc_q = '0, tx_i = '0, tx_q = '0;
   logic [SW-1:0] out_i, out_q;
   logic          out_valid;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int last_cyc = 0;
   logic [2*SW-1:0] model_cnt = '0;
   item_t sb[$];

   always #2 clk = ~clk;

   rxsrc_select #(.SAMPLE_W(SW), .DIV_W(DW), .WIDE_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_rst(rx_rst),
      .mode_word(mode_word), .rate_div(rate_div),
      .adc_i(adc_i), .adc_q(adc_q), .tx_i(tx_i), .tx_q(tx_q),
      .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Monitor: pops one expected item per valid pulse.
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R8", "unexpected valid", 1, 0);
         end else begin
            item_t it;
            it = sb.pop_front();
            check(out_i == it.i, it.tag, "out_i", int'(out_i), int'(it.i));
            check(out_q == it.q, it.tag, "out_q", int'(out_q), int'(it.q));
            if (it.gap != 0)
               check((cyc - last_cyc) == it.gap, "R6", "valid spacing",
                     cyc - last_cyc, it.gap);
         end
         last_cyc <= cyc;
      end
   end

   // Driver: programs a burst, predicts every output pair, runs it, stops.
   task automatic burst(input logic [2:0] mode, input int div, input int n,
                        input logic [SW-1:0] ai, input logic [SW-1:0] aq,
                        input logic [SW-1:0] ti, input logic [SW-1:0] tq,
                        input string tag);
      int eff;
      eff = (div < 2) ? 2 : div;
      @(negedge clk);
      mode_word = mode;
      rate_div  = DW'(div);
      adc_i = ai; adc_q = aq; tx_i = ti; tx_q = tq;
      for (int k = 0; k < n; k++) begin
         item_t it;
         it.gap = (k == 0) ? 0 : eff;
         it.tag = tag;
         if (mode[1] && mode[2]) begin
            it.i = model_cnt[SW-1:0];
            it.q = model_cnt[2*SW-1:SW];
         end else if (mode[1]) begin
            it.i = model_cnt[SW-1:0];
            it.q = ~model_cnt[SW-1:0];
         end else if (mode[0]) begin
            it.i = ti;
            it.q = tq;
         end else begin
            it.i = ai;
            it.q = aq;
         end
         model_cnt = model_cnt + 1'b1;
         sb.push_back(it);
      end
      rx_en = 1'b1;
      repeat (n * eff) @(posedge clk);
      @(negedge clk);
      rx_en = 1'b0;
      repeat (3) @(negedge clk);
      check(sb.size() == 0, tag, "items left over", sb.size(), 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
      check(out_i == '0 && out_q == '0, "R10", "outputs after reset",
            int'({out_i, out_q}), 0);

      burst(3'b000, 5, 4, 8'h12, 8'h34, 8'hA1, 8'hB2, "R1");
      burst(3'b100, 3, 3, 8'h56, 8'h78, 8'hA1, 8'hB2, "R1");
      burst(3'b001, 4, 3, 8'h11, 8'h22, 8'hC3, 8'hD4, "R2");
      burst(3'b101, 3, 2, 8'h11, 8'h22, 8'h5E, 8'h6F, "R2");
      burst(3'b010, 3, 5, 8'h11, 8'h22, 8'h33, 8'h44, "R3");
      burst(3'b011, 4, 3, 8'h11, 8'h22, 8'h33, 8'h44, "R5");
      burst(3'b010, 1, 4, 8'h00, 8'h00, 8'h00, 8'h00, "R7");
      burst(3'b010, 0, 3, 8'h00, 8'h00, 8'h00, 8'h00, "R7");

      // R8: disabled for a while, no valid; count resumes where it stopped
      repeat (20) @(negedge clk);
      check(out_valid == 1'b0, "R8", "valid while disabled", int'(out_valid), 0);
      burst(3'b010, 2, 2, 8'h00, 8'h00, 8'h00, 8'h00, "R8");

      // R9: receive reset overrides enable and clears the count
      @(negedge clk);
      rx_rst = 1'b1;
      rx_en  = 1'b1;
      rate_div = DW'(2);
      repeat (15) @(negedge clk);
      check(out_valid == 1'b0, "R9", "valid during rx reset", int'(out_valid), 0);
      rx_en  = 1'b0;
      rx_rst = 1'b0;
      model_cnt = '0;
      burst(3'b010, 2, 3, 8'h00, 8'h00, 8'h00, 8'h00, "R9");

      // R4: wide count, long enough to carry into the high half
      burst(3'b110, 2, 300, 8'h00, 8'h00, 8'h00, 8'h00, "R4");
      burst(3'b111, 3, 4, 8'h00, 8'h00, 8'h00, 8'h00, "R4");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule